// File: doc/BRIEF.md
# Serial EEPROM Write Receiver (Two-Wire Slave)

This block is the receive side of a two-wire serial EEPROM slave. It handles write transactions only. The two bus lines are sampled by the system clock and resynchronised. Bus framing conditions are decoded from the synchronised lines. The block then walks through a write frame: a control byte, a high and a low word-address byte, and one or more data bytes. It acknowledges a byte by pulling the data line low, through an open-drain enable output.

Each accepted data byte appears on a page-buffer port for one cycle, together with its 15-bit word address. The pointer advances only within its 64-byte page. When the frame ends with a Stop after at least one data byte, the block pulses a commit request to the memory core. While the core reports that it is busy, the block refuses every control byte. The bus master sees this as a missing acknowledge and polls until the write finishes.

Top module: `i2c_eeprom_wr_front`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid` and `commit` are all low.
- R2: A control byte, received most significant bit first, is acknowledged only when all of these hold: bits [7:4] equal 4'b1010, bits [3:1] equal `cs_strap`, bit 0 is 0 (write), and `mem_busy` is low. An acknowledge means `sda_oe` is high while SCL is high in the ninth clock of the byte.
- R3: After a control byte that is not acknowledged, the block does not acknowledge any byte and does not emit `wr_valid` or `commit` until the next Start.
- R4: A control byte that arrives while `mem_busy` is high is not acknowledged.
- R5: Both word-address bytes are acknowledged. The word address is {high[6:0], low[7:0]}. Bit 7 of the high byte is ignored.
- R6: Each data byte is acknowledged and produces exactly one single-cycle `wr_valid` pulse, with `wr_data` equal to the byte and `wr_addr` equal to the current word address.
- R7: After each data byte, bits [5:0] of the address increment modulo 64 and bits [14:6] stay unchanged.
- R8: A Stop received after at least one data byte produces exactly one single-cycle `commit` pulse.
- R9: A Stop received before any data byte produces no `commit`. A repeated Start aborts the frame without a `commit` and restarts control-byte decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired-AND bus value) |
| cs_strap | input | 3 | Static chip-select strap pins |
| mem_busy | input | 1 | Memory core write cycle in progress |
| sda_oe | output | 1 | Pull SDA low when high (acknowledge) |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 15 | Word address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit | output | 1 | One-cycle request to start the write cycle |

## Verification
If the frame state is wrong, it shows at the master's next acknowledge slot. The ninth SCL clock of the same byte either gains or loses the pulled-low SDA. A drift in the bit counter shifts the acknowledge into a data bit, and the next control or address byte exposes it. A broken address pointer shows only at the `wr_addr` of the following data byte, so the page-wrap test writes across the 63-to-0 boundary. A wrong commit decision shows within a few clocks of the Stop or repeated Start.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA
  } wr_state_e;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe;
  logic [PW-1:0] sda_pipe;

  // bus idles high, so reset the pipes to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_in};
      sda_pipe <= {sda_pipe[PW-2:0], sda_in};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[PW-2];
  assign scl_old = scl_pipe[PW-1];
  assign sda_now = sda_pipe[PW-2];
  assign sda_old = sda_pipe[PW-1];

  assign sda_bit   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              byte_ready,
  output logic              ack_end,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [CNT_W-1:0] bitcnt;
  logic             in_ack;

  assign byte_ready = scl_fall && (bitcnt == FULL) && !in_ack;
  assign ack_end    = scl_fall && in_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt  <= '0;
      in_ack  <= 1'b0;
      rx_byte <= '0;
    end else if (restart) begin
      bitcnt <= '0;
      in_ack <= 1'b0;
    end else if (scl_rise && bitcnt < FULL) begin
      rx_byte <= {rx_byte[DATA_W-2:0], sda_bit};
      bitcnt  <= bitcnt + 1'b1;
    end else if (byte_ready) begin
      in_ack <= 1'b1;
    end else if (ack_end) begin
      in_ack <= 1'b0;
      bitcnt <= '0;
    end
  end
endmodule

// File: rtl/i2cw_frame_fsm.sv
module i2cw_frame_fsm
  import i2cw_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          PAGE_W   = 6,
  parameter int          CS_W     = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_ready,
  input  logic              ack_end,
  input  logic [7:0]        rx_byte,
  input  logic [CS_W-1:0]   cs_strap,
  input  logic              mem_busy,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output wr_state_e         state
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ptr;
  logic              got_data;
  logic              byte_ok;
  wr_state_e         next_ok;

  always_comb begin
    byte_ok = 1'b0;
    next_ok = ST_IDLE;
    unique case (state)
      ST_CTRL: begin
        byte_ok = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == cs_strap)
                  && !rx_byte[0] && !mem_busy;
        next_ok = ST_ADDR_HI;
      end
      ST_ADDR_HI: begin byte_ok = 1'b1; next_ok = ST_ADDR_LO; end
      ST_ADDR_LO: begin byte_ok = 1'b1; next_ok = ST_DATA;    end
      ST_DATA:    begin byte_ok = 1'b1; next_ok = ST_DATA;    end
      default:    begin byte_ok = 1'b0; next_ok = ST_IDLE;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      commit   <= 1'b0;
      ptr      <= '0;
      got_data <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      commit   <= 1'b0;
      if (start_det) begin
        state    <= ST_CTRL;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (stop_det) begin
        commit   <= (state == ST_DATA) && got_data;
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (byte_ready && state != ST_IDLE) begin
        sda_oe <= byte_ok;
        unique case (state)
          ST_ADDR_HI: ptr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
          ST_ADDR_LO: ptr[7:0]        <= rx_byte;
          ST_DATA: begin
            wr_valid <= 1'b1;
            wr_addr  <= ptr;
            wr_data  <= rx_byte;
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end else if (ack_end && state != ST_IDLE) begin
        sda_oe <= 1'b0;
        state  <= sda_oe ? next_ok : ST_IDLE;
        if (sda_oe && state == ST_DATA)
          ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_wr_front.sv
module i2c_eeprom_wr_front
  import i2cw_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         PAGE_W      = 6,
  parameter int         CS_W        = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [CS_W-1:0]   cs_strap,
  input  logic              mem_busy,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit
);
  logic sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic byte_ready, ack_end;
  logic [7:0] rx_byte;
  wr_state_e  st;

  i2cw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_byte_rx #(.DATA_W(8)) u_rx (
    .clk(clk), .rst(rst), .restart(start_det | stop_det),
    .sda_bit(sda_bit), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .byte_ready(byte_ready), .ack_end(ack_end), .rx_byte(rx_byte)
  );

  i2cw_frame_fsm #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CS_W(CS_W), .DEV_CODE(DEV_CODE)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_ready(byte_ready), .ack_end(ack_end), .rx_byte(rx_byte),
    .cs_strap(cs_strap), .mem_busy(mem_busy), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .state(st)
  );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
  import i2cw_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      sda_oe,
  input logic      wr_valid,
  input logic      commit,
  input logic      mem_busy,
  input wr_state_e st
);
  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_wr_in_data_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> st == ST_DATA);

  assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  assert_commit_after_data_R9: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(st) == ST_DATA);

  assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && st == ST_CTRL) |-> !$past(mem_busy));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !sda_oe);
endmodule

bind i2c_eeprom_wr_front i2cw_checker u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .commit(commit), .mem_busy(mem_busy), .st(st)
);

// File: tb/test_i2c_eeprom_wr_front.sv
module test_i2c_eeprom_wr_front;
  localparam int Q = 8;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] CTRL_OK = {4'b1010, CS, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic mem_busy = 1'b0;
  logic sda_oe, wr_valid, commit;
  logic [14:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_wr_front i_i2c_eeprom_wr_front (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .cs_strap(CS), .mem_busy(mem_busy), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_commit = 0;
  logic [14:0] cap_addr [0:15];
  logic [7:0]  cap_data [0:15];
  bit done = 0;

  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      cap_addr[n_wr % 16] = wr_addr;
      cap_data[n_wr % 16] = wr_data;
      n_wr++;
    end
    if (!rst && commit) n_commit++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(4 * Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl = 1'b1; wait_q(Q);
      scl = 1'b0; wait_q(Q);
    end
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1; wait_q(Q / 2);
    ack = sda_oe;
    wait_q(Q / 2);
    scl = 1'b0; wait_q(Q);
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    check(commit == 1'b0, "R1 commit", commit, 0);
  endtask

  task automatic t_byte_write;
    bit a; int w0 = n_wr; int c0 = n_commit;
    bus_start;
    bus_byte(CTRL_OK, a); check(a, "R2 ctrl ack", a, 1);
    bus_byte(8'h12, a);   check(a, "R5 addr hi ack", a, 1);
    bus_byte(8'h34, a);   check(a, "R5 addr lo ack", a, 1);
    bus_byte(8'hA5, a);   check(a, "R6 data ack", a, 1);
    bus_stop;
    check(n_wr - w0 == 1, "R6 one strobe", n_wr - w0, 1);
    check(cap_addr[w0 % 16] == 15'h1234, "R6 addr", cap_addr[w0 % 16], 15'h1234);
    check(cap_data[w0 % 16] == 8'hA5, "R6 data", cap_data[w0 % 16], 8'hA5);
    check(n_commit - c0 == 1, "R8 commit", n_commit - c0, 1);
  endtask

  task automatic t_reject(input logic [7:0] ctrl, input string req);
    bit a; int w0 = n_wr; int c0 = n_commit;
    bus_start;
    bus_byte(ctrl, a); check(!a, req, a, 0);
    bus_byte(8'h00, a); check(!a, "R3 later byte no ack", a, 0);
    bus_byte(8'h55, a); check(!a, "R3 later byte no ack", a, 0);
    bus_stop;
    check(n_wr == w0, "R3 no strobe", n_wr - w0, 0);
    check(n_commit == c0, "R3 no commit", n_commit - c0, 0);
  endtask

  task automatic t_busy;
    bit a;
    mem_busy = 1'b1;
    bus_start;
    bus_byte(CTRL_OK, a); check(!a, "R4 busy no ack", a, 0);
    bus_stop;
    mem_busy = 1'b0;
  endtask

  task automatic t_page_wrap;
    bit a; int w0 = n_wr; int c0 = n_commit;
    logic [14:0] exp_a [0:3];
    logic [7:0]  vals  [0:3];
    exp_a[0] = 15'h013E; exp_a[1] = 15'h013F; exp_a[2] = 15'h0100; exp_a[3] = 15'h0101;
    vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h33; vals[3] = 8'h44;
    bus_start;
    bus_byte(CTRL_OK, a); check(a, "R2 ctrl ack", a, 1);
    bus_byte(8'h81, a);   check(a, "R5 addr hi ack", a, 1);
    bus_byte(8'h3E, a);   check(a, "R5 addr lo ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      bus_byte(vals[k], a); check(a, "R6 data ack", a, 1);
    end
    bus_stop;
    check(n_wr - w0 == 4, "R6 strobes", n_wr - w0, 4);
    for (int k = 0; k < 4; k++) begin
      check(cap_addr[(w0 + k) % 16] == exp_a[k], "R7 page wrap addr",
            cap_addr[(w0 + k) % 16], exp_a[k]);
      check(cap_data[(w0 + k) % 16] == vals[k], "R6 data", cap_data[(w0 + k) % 16], vals[k]);
    end
    check(n_commit - c0 == 1, "R8 commit", n_commit - c0, 1);
  endtask

  task automatic t_stop_early;
    bit a; int c0 = n_commit; int w0 = n_wr;
    bus_start;
    bus_byte(CTRL_OK, a); bus_byte(8'h00, a); bus_byte(8'h10, a);
    bus_stop;
    check(n_commit == c0, "R9 no commit on early stop", n_commit - c0, 0);
    check(n_wr == w0, "R9 no strobe", n_wr - w0, 0);
  endtask

  task automatic t_rep_start;
    bit a; int c0 = n_commit; int w0 = n_wr;
    bus_start;
    bus_byte(CTRL_OK, a); bus_byte(8'h00, a); bus_byte(8'h20, a);
    bus_start;
    bus_byte(CTRL_OK, a); check(a, "R9 ctrl after repeated start", a, 1);
    bus_byte(8'h00, a); bus_byte(8'h40, a);
    bus_byte(8'h77, a); check(a, "R6 data ack", a, 1);
    bus_stop;
    check(n_wr - w0 == 1, "R9 one strobe", n_wr - w0, 1);
    check(cap_addr[w0 % 16] == 15'h0040, "R9 new address", cap_addr[w0 % 16], 15'h0040);
    check(n_commit - c0 == 1, "R9 single commit", n_commit - c0, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    wait_q(4);
    t_reset;
    t_byte_write;
    t_reject({4'b1010, 3'b001, 1'b0}, "R3 cs mismatch no ack");
    t_reject({4'b1011, CS, 1'b0}, "R2 code mismatch no ack");
    t_reject({4'b1010, CS, 1'b1}, "R2 read bit no ack");
    t_busy;
    t_byte_write;
    t_page_wrap;
    t_stop_early;
    t_rep_start;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule